// File: doc/BRIEF.md
# Peer Setup Message Decoder

The decoder takes a byte stream from a control server and packs it into 64-bit signed messages, least significant byte first. Bytes may arrive with idle cycles between them. Along with the last byte of each message comes a sideband flag that says whether a descriptor travelled with the message. Once a message is complete, the block steps through a setup sequence. A version word comes first, then the device's own identifier. After that it accepts any mix of connect and disconnect messages, and a one-time shared-memory message with the value -1 ends setup.

For each peer, the block keeps a count of connected vectors. It also tracks how many peer slots are in use. Every connect is reported as an event carrying the peer and the vector number implied by it. Any protocol violation produces a one-cycle error pulse with a code. A violation before setup completes is fatal, and the block then ignores all input until reset. A violation after setup is reported and then skipped. When setup is done, the block resolves the master role from the role mode input and its own identifier.

Top module: `peer_setup_decoder`

## Requirements
- R1: Eight accepted bytes form one message, the first byte being bits 7:0. Idle cycles between bytes are allowed, and the byte count restarts at zero after each message.
- R2: The first message must equal PROTO_VERSION (default 0) and carry no descriptor. Otherwise the block pulses error code 1 and enters the fatal state.
- R3: The second message must carry no descriptor and lie in 0..65535. It then becomes ownId. Otherwise the block pulses error code 2 and enters the fatal state.
- R4: After the identifier, a value below -1 or above 65535 pulses error code 3 and changes no table state.
- R5: The value -1 raises setupDone, which then stays high. A second -1 pulses error code 4.
- R6: peerCount resets to 16. A valid peer value v with v ≥ peerCount sets peerCount to v+1, and this applies to connects and disconnects alike. A value of PEER_DEPTH (default 64) or more pulses error code 7 and changes nothing.
- R7: A message with a descriptor is a connect. It reports connStb with connVector equal to the number of earlier connects for that peer, then increments that count. If the count has already reached VECTORS (default 4), the block pulses error code 5 instead.
- R8: A message without a descriptor is a disconnect. It clears the peer's vector count. A disconnect of ownId pulses error code 6.
- R9: Any error before setupDone rises is fatal. Later messages then cause no pulse, no event and no state change. An error after setupDone does not stop later messages from being processed.
- R10: With setupDone high, isMaster follows roleMode: 2'b10 means master, 2'b01 means peer, and any other value means master only if ownId is 0. Before setupDone, isMaster is 0.
- R11: qVectors returns the vector count of peer qPeer combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | A stream byte is present this cycle |
| byteData | input | 8 | Stream byte |
| fdFlag | input | 1 | Descriptor present, sampled with the last byte of a message |
| roleMode | input | 2 | 00/11 auto, 01 peer, 10 master |
| qPeer | input | 6 | Peer index to query |
| setupDone | output | 1 | Shared-memory message received |
| isMaster | output | 1 | Resolved master role |
| ownId | output | 16 | Captured own identifier |
| peerCount | output | 17 | Peer slots in use |
| qVectors | output | 3 | Vector count of qPeer |
| connStb | output | 1 | One-cycle connect event |
| connPeer | output | 16 | Peer of the connect event |
| connVector | output | 3 | Vector assigned by the connect event |
| errPulse | output | 1 | One-cycle error indication |
| errCode | output | 3 | Error code while errPulse is high |

## Verification
A slipped byte counter misaligns every later message. The first visible sign is usually a wrong version or identifier error two cycles after the eighth byte. A corrupted vector count appears on the next connect to that peer as a wrong connVector, and it appears immediately on qVectors. A state machine that fails to hold the fatal state would show events or pulses after a setup error, and a wrong resolved role shows on isMaster once setupDone rises.

// File: rtl/psd_pkg.sv
package psd_pkg;
  typedef enum logic [2:0] {
    ERR_NONE      = 3'd0,
    ERR_VERSION   = 3'd1,
    ERR_ID        = 3'd2,
    ERR_RANGE     = 3'd3,
    ERR_SHM_AGAIN = 3'd4,
    ERR_VEC_FULL  = 3'd5,
    ERR_SELF_DISC = 3'd6,
    ERR_TABLE     = 3'd7
  } err_e;

  typedef enum logic [2:0] {
    ST_VER, ST_ID, ST_LOOP, ST_RUN, ST_FAIL
  } state_e;

  localparam logic [1:0] ROLE_PEER   = 2'b01;
  localparam logic [1:0] ROLE_MASTER = 2'b10;

  typedef struct packed {
    logic capId;
    logic grow;
    logic connect;
    logic disconnect;
    logic markShm;
  } strobe_t;

  typedef struct packed {
    logic msgReady;
    logic msgFd;
    logic isVersion;
    logic isNegOne;
    logic outOfRange;
    logic beyondTable;
    logic needGrow;
    logic vecFull;
    logic isOwn;
    logic shmSeen;
    logic ownIdZero;
  } status_t;
endpackage

// File: rtl/psd_datapath.sv
module psd_datapath
  import psd_pkg::*;
#(
  parameter int PEER_DEPTH = 64,
  parameter int VECTORS = 4,
  parameter int INIT_PEERS = 16,
  parameter logic [63:0] PROTO_VERSION = 64'd0,
  localparam int IDX_W = $clog2(PEER_DEPTH),
  localparam int CNT_W = $clog2(VECTORS + 1),
  localparam int PC_W = 17
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             byteValid,
  input  logic [7:0]       byteData,
  input  logic             fdFlag,
  input  logic [IDX_W-1:0] qPeer,
  input  strobe_t          strb,
  output status_t          stat,
  output logic             setupDone,
  output logic [15:0]      ownId,
  output logic [PC_W-1:0]  peerCount,
  output logic [CNT_W-1:0] qVectors,
  output logic             connStb,
  output logic [15:0]      connPeer,
  output logic [CNT_W-1:0] connVector
);
  logic [2:0]  byteCnt;
  logic [55:0] lowBytes;
  logic [63:0] msgWord;
  logic        msgReady;
  logic        msgFd;
  logic        shmSeen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteCnt  <= '0;
      lowBytes <= '0;
      msgWord  <= '0;
      msgReady <= 1'b0;
      msgFd    <= 1'b0;
    end else begin
      msgReady <= 1'b0;
      if (byteValid) begin
        if (byteCnt == 3'd7) begin
          msgWord  <= {byteData, lowBytes};
          msgFd    <= fdFlag;
          msgReady <= 1'b1;
          byteCnt  <= '0;
        end else begin
          lowBytes <= {byteData, lowBytes[55:8]};
          byteCnt  <= byteCnt + 3'd1;
        end
      end
    end
  end

  AST_BYTE_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && byteCnt == 3'd7) |=> (byteCnt == 3'd0 && msgReady)); // R1

  logic [15:0]      msgId;
  logic [IDX_W-1:0] msgIdx;
  logic [CNT_W-1:0] vecCnt [PEER_DEPTH];

  assign msgId  = msgWord[15:0];
  assign msgIdx = msgId[IDX_W-1:0];

  always_comb begin
    stat.msgReady    = msgReady;
    stat.msgFd       = msgFd;
    stat.isVersion   = (msgWord == PROTO_VERSION);
    stat.isNegOne    = &msgWord;
    stat.outOfRange  = msgWord[63] ? !(&msgWord) : (|msgWord[62:16]);
    stat.beyondTable = ({1'b0, msgId} >= PC_W'(PEER_DEPTH));
    stat.needGrow    = ({1'b0, msgId} >= peerCount);
    stat.vecFull     = (vecCnt[msgIdx] >= CNT_W'(VECTORS));
    stat.isOwn       = (msgId == ownId);
    stat.shmSeen     = shmSeen;
    stat.ownIdZero   = (ownId == 16'd0);
  end

  for (genvar i = 0; i < PEER_DEPTH; i++) begin : g_entry
    logic hit;
    assign hit = (msgIdx == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        vecCnt[i] <= '0;
      end else if (strb.connect && hit) begin
        vecCnt[i] <= vecCnt[i] + CNT_W'(1);
      end else if (strb.disconnect && hit) begin
        vecCnt[i] <= '0;
      end else if (strb.grow && PC_W'(i) >= peerCount && IDX_W'(i) <= msgIdx) begin
        vecCnt[i] <= '0;
      end
    end
  end

  assign qVectors = vecCnt[qPeer];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      peerCount  <= PC_W'(INIT_PEERS);
      ownId      <= '0;
      shmSeen    <= 1'b0;
      connStb    <= 1'b0;
      connPeer   <= '0;
      connVector <= '0;
    end else begin
      connStb <= strb.connect;
      if (strb.grow)    peerCount <= {1'b0, msgId} + PC_W'(1);
      if (strb.capId)   ownId <= msgId;
      if (strb.markShm) shmSeen <= 1'b1;
      if (strb.connect) begin
        connPeer   <= msgId;
        connVector <= vecCnt[msgIdx];
      end
    end
  end

  assign setupDone = shmSeen;

  AST_PEER_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !msgReady |=> $stable(peerCount)); // R6
  AST_SHM_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    shmSeen |=> shmSeen); // R5
  AST_CONN_VEC: assert property (@(posedge clk) disable iff (!rstN)
    connStb |-> (connVector < CNT_W'(VECTORS))); // R7
endmodule

// File: rtl/psd_control.sv
module psd_control
  import psd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  status_t    stat,
  input  logic [1:0] roleMode,
  output strobe_t    strb,
  output logic       isMaster,
  output logic       errPulse,
  output logic [2:0] errCode
);
  state_e state, stateNext;
  err_e   errNext;

  always_comb begin
    stateNext = state;
    errNext   = ERR_NONE;
    strb      = '0;
    if (stat.msgReady) begin
      unique case (state)
        ST_VER: begin
          if (stat.isVersion && !stat.msgFd) stateNext = ST_ID;
          else errNext = ERR_VERSION;
        end
        ST_ID: begin
          if (!stat.msgFd && !stat.isNegOne && !stat.outOfRange) begin
            strb.capId = 1'b1;
            stateNext  = ST_LOOP;
          end else begin
            errNext = ERR_ID;
          end
        end
        ST_LOOP, ST_RUN: begin
          if (stat.outOfRange) begin
            errNext = ERR_RANGE;
          end else if (stat.isNegOne) begin
            if (stat.shmSeen) errNext = ERR_SHM_AGAIN;
            else begin
              strb.markShm = 1'b1;
              stateNext    = ST_RUN;
            end
          end else if (stat.beyondTable) begin
            errNext = ERR_TABLE;
          end else begin
            strb.grow = stat.needGrow;
            if (stat.msgFd) begin
              if (stat.vecFull) errNext = ERR_VEC_FULL;
              else strb.connect = 1'b1;
            end else begin
              if (stat.isOwn) errNext = ERR_SELF_DISC;
              else strb.disconnect = 1'b1;
            end
          end
        end
        default: ;
      endcase
      if (errNext != ERR_NONE && state != ST_RUN) stateNext = ST_FAIL;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_VER;
      errPulse <= 1'b0;
      errCode  <= ERR_NONE;
    end else begin
      state    <= stateNext;
      errPulse <= (errNext != ERR_NONE);
      errCode  <= errNext;
    end
  end

  always_comb begin
    if (!stat.shmSeen)               isMaster = 1'b0;
    else if (roleMode == ROLE_MASTER) isMaster = 1'b1;
    else if (roleMode == ROLE_PEER)   isMaster = 1'b0;
    else                              isMaster = stat.ownIdZero;
  end

  AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FAIL) |=> (state == ST_FAIL && !errPulse)); // R9
  AST_FAIL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FAIL) |-> (strb == '0)); // R9
endmodule

// File: rtl/peer_setup_decoder.sv
module peer_setup_decoder
  import psd_pkg::*;
#(
  parameter int PEER_DEPTH = 64,
  parameter int VECTORS = 4,
  parameter int INIT_PEERS = 16,
  parameter logic [63:0] PROTO_VERSION = 64'd0,
  localparam int IDX_W = $clog2(PEER_DEPTH),
  localparam int CNT_W = $clog2(VECTORS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             byteValid,
  input  logic [7:0]       byteData,
  input  logic             fdFlag,
  input  logic [1:0]       roleMode,
  input  logic [IDX_W-1:0] qPeer,
  output logic             setupDone,
  output logic             isMaster,
  output logic [15:0]      ownId,
  output logic [16:0]      peerCount,
  output logic [CNT_W-1:0] qVectors,
  output logic             connStb,
  output logic [15:0]      connPeer,
  output logic [CNT_W-1:0] connVector,
  output logic             errPulse,
  output logic [2:0]       errCode
);
  strobe_t strb;
  status_t stat;

  psd_datapath #(
    .PEER_DEPTH(PEER_DEPTH), .VECTORS(VECTORS),
    .INIT_PEERS(INIT_PEERS), .PROTO_VERSION(PROTO_VERSION)
  ) u_dp (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteData(byteData),
    .fdFlag(fdFlag), .qPeer(qPeer), .strb(strb), .stat(stat),
    .setupDone(setupDone), .ownId(ownId), .peerCount(peerCount),
    .qVectors(qVectors), .connStb(connStb), .connPeer(connPeer),
    .connVector(connVector)
  );

  psd_control u_ctl (
    .clk(clk), .rstN(rstN), .stat(stat), .roleMode(roleMode),
    .strb(strb), .isMaster(isMaster), .errPulse(errPulse), .errCode(errCode)
  );
endmodule

// File: tb/peer_setup_decoder_bench.sv
`timescale 1ns/1ps
module peer_setup_decoder_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteData = '0;
  logic        fdFlag = 1'b0;
  logic [1:0]  roleMode = 2'b00;
  logic [5:0]  qPeer = '0;
  logic        setupDone, isMaster, connStb, errPulse;
  logic [15:0] ownId, connPeer;
  logic [16:0] peerCount;
  logic [2:0]  qVectors, connVector, errCode;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  peer_setup_decoder u_peer_setup_decoder (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteData(byteData),
    .fdFlag(fdFlag), .roleMode(roleMode), .qPeer(qPeer),
    .setupDone(setupDone), .isMaster(isMaster), .ownId(ownId),
    .peerCount(peerCount), .qVectors(qVectors), .connStb(connStb),
    .connPeer(connPeer), .connVector(connVector), .errPulse(errPulse),
    .errCode(errCode)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    byteValid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // returns at the negedge where the message's effects are visible
  task automatic sendMsg(input longint v, input bit fd, input bit gap);
    for (int b = 0; b < 8; b++) begin
      @(negedge clk);
      byteValid = 1'b1;
      byteData  = v[b*8 +: 8];
      fdFlag    = fd;
      if (gap) begin
        @(negedge clk);
        byteValid = 1'b0;
      end
    end
    if (!gap) begin
      @(negedge clk);
      byteValid = 1'b0;
    end
    fdFlag = 1'b0;
    @(negedge clk);
  endtask

  task automatic expectErr(input string req, input int code);
    check({req, " errPulse"}, longint'(errPulse), (code != 0) ? 1 : 0);
    if (code != 0) check({req, " errCode"}, longint'(errCode), code);
  endtask

  task automatic testReset();
    doReset();
    check("R6 reset peerCount", longint'(peerCount), 16);
    check("R5 reset setupDone", longint'(setupDone), 0);
    check("R10 reset isMaster", longint'(isMaster), 0);
    expectErr("R9 reset", 0);
    qPeer = 6'd3;
    #1 check("R11 reset qVectors", longint'(qVectors), 0);
  endtask

  task automatic testBadVersion();
    doReset();
    sendMsg(5, 1'b0, 1'b0);
    expectErr("R2 wrong version", 1);
    sendMsg(0, 1'b0, 1'b0);
    expectErr("R9 ignored after fail", 0);
    sendMsg(1, 1'b0, 1'b0);
    sendMsg(-1, 1'b0, 1'b0);
    check("R9 no setupDone after fail", longint'(setupDone), 0);
    check("R9 ownId untouched", longint'(ownId), 0);
    doReset();
    sendMsg(0, 1'b1, 1'b0);
    expectErr("R2 version with descriptor", 1);
  endtask

  task automatic testBadId();
    doReset();
    sendMsg(0, 1'b0, 1'b0);
    expectErr("R2 good version", 0);
    sendMsg(2, 1'b1, 1'b0);
    expectErr("R3 id with descriptor", 2);
    doReset();
    sendMsg(0, 1'b0, 1'b0);
    sendMsg(70000, 1'b0, 1'b0);
    expectErr("R3 id above range", 2);
    doReset();
    sendMsg(0, 1'b0, 1'b0);
    sendMsg(2, 1'b0, 1'b0);
    sendMsg(2, 1'b0, 1'b0);
    expectErr("R8 self disconnect during setup", 6);
    sendMsg(-1, 1'b0, 1'b0);
    check("R9 setup error is fatal", longint'(setupDone), 0);
  endtask

  task automatic testMain();
    roleMode = 2'b00;
    doReset();
    sendMsg(0, 1'b0, 1'b1);
    sendMsg(3, 1'b0, 1'b1);
    expectErr("R1 gapped id accepted", 0);
    check("R1 R3 ownId", longint'(ownId), 3);
    sendMsg(5, 1'b1, 1'b0);
    check("R7 first connect strobe", longint'(connStb), 1);
    check("R7 first connect vector", longint'(connVector), 0);
    check("R7 connect peer", longint'(connPeer), 5);
    sendMsg(5, 1'b1, 1'b0);
    check("R7 second connect vector", longint'(connVector), 1);
    qPeer = 6'd5;
    #1 check("R11 qVectors peer 5", longint'(qVectors), 2);
    check("R6 no growth below count", longint'(peerCount), 16);
    sendMsg(20, 1'b1, 1'b0);
    check("R6 grow on connect", longint'(peerCount), 21);
    check("R7 new peer vector", longint'(connVector), 0);
    check("R5 not done before shm", longint'(setupDone), 0);
    sendMsg(-1, 1'b0, 1'b0);
    expectErr("R5 first shm", 0);
    check("R5 setupDone", longint'(setupDone), 1);
    check("R10 auto role nonzero id", longint'(isMaster), 0);
    sendMsg(-2, 1'b0, 1'b0);
    expectErr("R4 below minus one", 3);
    sendMsg(70000, 1'b1, 1'b0);
    expectErr("R4 above range", 3);
    check("R4 no connect on bad value", longint'(connStb), 0);
    check("R4 peerCount unchanged", longint'(peerCount), 21);
    sendMsg(1, 1'b1, 1'b0);
    check("R9 processing continues after error", longint'(connStb), 1);
    sendMsg(-1, 1'b0, 1'b0);
    expectErr("R5 second shm", 4);
    sendMsg(5, 1'b1, 1'b0);
    check("R7 third vector", longint'(connVector), 2);
    sendMsg(5, 1'b1, 1'b0);
    check("R7 fourth vector", longint'(connVector), 3);
    sendMsg(5, 1'b1, 1'b0);
    expectErr("R7 vector overflow", 5);
    check("R7 no strobe on overflow", longint'(connStb), 0);
    qPeer = 6'd5;
    #1 check("R7 count held at limit", longint'(qVectors), 4);
    sendMsg(5, 1'b0, 1'b0);
    expectErr("R8 disconnect ok", 0);
    check("R8 count cleared", longint'(qVectors), 0);
    sendMsg(3, 1'b0, 1'b0);
    expectErr("R8 self disconnect", 6);
    sendMsg(64, 1'b1, 1'b0);
    expectErr("R6 beyond table", 7);
    check("R6 no growth beyond table", longint'(peerCount), 21);
    sendMsg(40, 1'b0, 1'b0);
    check("R6 grow on disconnect", longint'(peerCount), 41);
    sendMsg(5, 1'b1, 1'b1);
    check("R8 reconnect restarts at vector 0", longint'(connVector), 0);
  endtask

  task automatic testRole();
    roleMode = 2'b00;
    doReset();
    sendMsg(0, 1'b0, 1'b0);
    sendMsg(0, 1'b0, 1'b0);
    check("R10 not master before shm", longint'(isMaster), 0);
    sendMsg(-1, 1'b0, 1'b0);
    check("R10 auto role id zero", longint'(isMaster), 1);
    roleMode = 2'b01;
    #1 check("R10 explicit peer", longint'(isMaster), 0);
    roleMode = 2'b10;
    #1 check("R10 explicit master", longint'(isMaster), 1);
    roleMode = 2'b11;
    #1 check("R10 code 11 is auto", longint'(isMaster), 1);
    roleMode = 2'b00;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    testReset();
    testBadVersion();
    testBadId();
    testMain();
    testRole();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule